// File: doc/BRIEF.md
# Triggered Pattern Pulse Sequencer

The block produces a shaped pulse train on a single output after an external trigger. Everything runs on one fast input clock. A divider derives a logic-rate enable that fires once every `RATIO_M1 + 1` fast cycles. A synchronised trigger edge arms a sequencer. At the next logic tick a position counter starts at 0. It then advances one step per tick through every address of two one-bit pattern tables: an "up" table that marks instants where the output should rise and a "down" table that marks instants where it should fall. A marked position gives a one-logic-cycle strobe. Each strobe is trimmed to a single fast-cycle pulse, delayed by its own programmable count of fast cycles, and applied to a set/clear output register. That register gives sub-logic-cycle placement of both edges.

The sequencer is a three-state machine. The states are `ST_IDLE`, `ST_ARMED` and `ST_RUN`.
- `ST_IDLE` parks the counter on its last address.
- A synchronised trigger edge takes `ST_IDLE` to `ST_ARMED`.
- The next logic tick takes `ST_ARMED` to `ST_RUN` and loads position 0.
- A tick taken while the last position is addressed takes `ST_RUN` back to `ST_IDLE`.
- In every other case the state holds.

The pattern tables are loaded through a small write port that acts only on logic ticks.

Top module: `pulse_pattern_gen`

## Requirements
- R1: After reset `pulse_out` is 0 and both tables hold all zeros, so a run over unwritten tables leaves `pulse_out` at 0.
- R2: The logic tick occurs on every fast edge whose count since reset release is a multiple of `RATIO_M1 + 1`. The first tick is edge number `RATIO_M1 + 1`. The table write port (`cfg_we`, `cfg_addr`, `cfg_up_bit`, `cfg_dn_bit`) takes effect only on a tick edge. A `cfg_we` pulse that spans no tick edge changes nothing.
- R3: A trigger edge is `trig_in` sampled 1 at fast edge k after being sampled 0 at edge k-1. It is accepted at edge k+2 if the sequencer is idle then. The run starts, with position 0, at the first tick edge S after edge k+2.
- R4: During a run the position advances by one on each tick edge, through 0 to 2^`ADDR_W` - 1. The sequencer is idle again after the tick edge S + (`RATIO_M1`+1)·2^`ADDR_W`. While idle the counter holds the last position.
- R5: An up bit at position c sets `pulse_out` to 1 at fast edge S + (`RATIO_M1`+1)·(c+1) + 1 + `up_delay`. A down bit at c clears it to 0 at the same formula with `dn_delay`. Each marked position acts exactly once per run.
- R6: `up_delay` and `dn_delay` each range over 0..`RATIO_M1` fast cycles and act independently of each other.
- R7: When both the up and the down event land on the same fast edge, the clear wins and `pulse_out` is 0. So with both bits at one position, the pulse is `dn_delay - up_delay` fast cycles wide, and it is absent when the delays are equal.
- R8: A trigger edge that arrives while the sequencer is armed or running is ignored. It neither restarts nor extends the run.
- R9: The parked counter in idle produces no strobes, even when the last position is marked in either table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock; all state is clocked here |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | 1 | Asynchronous trigger, rising edge starts a run |
| cfg_we | input | 1 | Table write enable, applied on a logic tick |
| cfg_addr | input | ADDR_W | Table position written |
| cfg_up_bit | input | 1 | Value stored in the up (rise) table |
| cfg_dn_bit | input | 1 | Value stored in the down (fall) table |
| up_delay | input | DLY_W | Fast-cycle delay applied to rise events |
| dn_delay | input | DLY_W | Fast-cycle delay applied to fall events |
| pulse_out | output | 1 | Set/clear registered pulse output |

## Verification
The bound checker watches several rules on every cycle:
- the position steps by exactly one per tick during a run, returns to idle after the last position, and stays parked on the last position in idle;
- a run never re-arms;
- strobes only follow running cycles;
- every output rise or fall is traced to a delayed up or down event, and simultaneous events leave the output low.

Only the bench scenarios can show the absolute timing. That covers trigger-to-start alignment against the tick phase, the exact fast edge of each output transition under different delay pairs, pulse widths from shared positions, ignored retriggers, and a write pulse that misses every tick.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } seq_state_e;
endpackage

// File: rtl/ppg_tick_gen.sv
// Logic-rate enable derived from the fast clock.
module ppg_tick_gen #(
    parameter int RATIO_M1 = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick,
    output logic phase0
);
    localparam int DIVW = (RATIO_M1 > 0) ? $clog2(RATIO_M1 + 1) : 1;

    logic [DIVW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (div_q == DIVW'(RATIO_M1)) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // tick marks the fast cycle that ends a logic period
    assign tick   = (div_q == DIVW'(RATIO_M1));
    // phase0 marks the first fast cycle of a logic period
    assign phase0 = (div_q == '0);
endmodule

// File: rtl/ppg_trig_sync.sv
// Two-stage synchroniser plus edge detector for the trigger.
module ppg_trig_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_async,
    output logic trig_rise
);
    logic [2:0] sync_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[1:0], trig_async};
        end
    end

    assign trig_rise = sync_q[1] & ~sync_q[2];
endmodule

// File: rtl/ppg_bitmem.sv
// One-bit pattern table: write on tick, registered gated read on tick.
module ppg_bitmem #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic              wbit,
    input  logic              ren,
    input  logic [ADDR_W-1:0] raddr,
    output logic              strobe
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0] bits_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
            strobe <= 1'b0;
        end else if (tick) begin
            if (we) begin
                bits_q[waddr] <= wbit;
            end
            strobe <= ren & bits_q[raddr];
        end
    end
endmodule

// File: rtl/ppg_tap_delay.sv
// Fast-cycle delay line with a selectable tap (0 = undelayed).
module ppg_tap_delay #(
    parameter int MAXD = 3,
    parameter int SELW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_pulse,
    input  logic [SELW-1:0] sel,
    output logic            out_pulse
);
    generate
        if (MAXD == 0) begin : g_bypass
            logic unused_sel;
            assign unused_sel = ^sel;
            assign out_pulse  = in_pulse;
        end else begin : g_line
            logic [MAXD-1:0] line_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    line_q <= '0;
                end else begin
                    line_q[0] <= in_pulse;
                    for (int i = 1; i < MAXD; i++) begin
                        line_q[i] <= line_q[i-1];
                    end
                end
            end

            always_comb begin
                out_pulse = in_pulse;
                for (int i = 1; i <= MAXD; i++) begin
                    if (int'(sel) == i) begin
                        out_pulse = line_q[i-1];
                    end
                end
                if (int'(sel) > MAXD) begin
                    out_pulse = line_q[MAXD-1];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/pulse_pattern_gen.sv
module pulse_pattern_gen
    import ppg_pkg::*;
#(
    parameter  int RATIO_M1 = 3,
    parameter  int ADDR_W   = 4,
    localparam int DLY_W    = (RATIO_M1 > 0) ? $clog2(RATIO_M1 + 1) : 1
) (
    input  logic              clk_in,
    input  logic              rst_n,
    input  logic              trig_in,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_up_bit,
    input  logic              cfg_dn_bit,
    input  logic [DLY_W-1:0]  up_delay,
    input  logic [DLY_W-1:0]  dn_delay,
    output logic              pulse_out
);
    localparam logic [ADDR_W-1:0] LAST_POS = {ADDR_W{1'b1}};

    logic tick;
    logic phase0;
    logic trig_rise;

    seq_state_e        state_q, state_d;
    logic [ADDR_W-1:0] pos_q, pos_d;

    logic up_stb, dn_stb;
    logic up_fire, dn_fire;
    logic up_late, dn_late;
    logic running;

    ppg_tick_gen #(.RATIO_M1(RATIO_M1)) u_tick (
        .clk    (clk_in),
        .rst_n  (rst_n),
        .tick   (tick),
        .phase0 (phase0)
    );

    ppg_trig_sync u_sync (
        .clk        (clk_in),
        .rst_n      (rst_n),
        .trig_async (trig_in),
        .trig_rise  (trig_rise)
    );

    // Sequencer state register
    always_ff @(posedge clk_in) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pos_q   <= LAST_POS;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
        end
    end

    // Sequencer next-state and counter logic
    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        unique case (state_q)
            ST_IDLE: begin
                pos_d = LAST_POS;
                if (trig_rise) begin
                    state_d = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (tick) begin
                    state_d = ST_RUN;
                    pos_d   = '0;
                end
            end
            ST_RUN: begin
                if (tick) begin
                    if (pos_q == LAST_POS) begin
                        state_d = ST_IDLE;
                    end else begin
                        pos_d = pos_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
                pos_d   = LAST_POS;
            end
        endcase
    end

    assign running = (state_q == ST_RUN);

    ppg_bitmem #(.ADDR_W(ADDR_W)) u_up_mem (
        .clk    (clk_in),
        .rst_n  (rst_n),
        .tick   (tick),
        .we     (cfg_we),
        .waddr  (cfg_addr),
        .wbit   (cfg_up_bit),
        .ren    (running),
        .raddr  (pos_q),
        .strobe (up_stb)
    );

    ppg_bitmem #(.ADDR_W(ADDR_W)) u_dn_mem (
        .clk    (clk_in),
        .rst_n  (rst_n),
        .tick   (tick),
        .we     (cfg_we),
        .waddr  (cfg_addr),
        .wbit   (cfg_dn_bit),
        .ren    (running),
        .raddr  (pos_q),
        .strobe (dn_stb)
    );

    // Trim each logic-cycle strobe to its first fast cycle
    assign up_fire = up_stb & phase0;
    assign dn_fire = dn_stb & phase0;

    ppg_tap_delay #(.MAXD(RATIO_M1), .SELW(DLY_W)) u_up_dly (
        .clk       (clk_in),
        .rst_n     (rst_n),
        .in_pulse  (up_fire),
        .sel       (up_delay),
        .out_pulse (up_late)
    );

    ppg_tap_delay #(.MAXD(RATIO_M1), .SELW(DLY_W)) u_dn_dly (
        .clk       (clk_in),
        .rst_n     (rst_n),
        .in_pulse  (dn_fire),
        .sel       (dn_delay),
        .out_pulse (dn_late)
    );

    // Output register: clear has priority over set
    always_ff @(posedge clk_in) begin
        if (!rst_n) begin
            pulse_out <= 1'b0;
        end else if (dn_late) begin
            pulse_out <= 1'b0;
        end else if (up_late) begin
            pulse_out <= 1'b1;
        end
    end
endmodule

// File: rtl/ppg_checker.sv
module ppg_checker
    import ppg_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input seq_state_e        state,
    input logic [ADDR_W-1:0] pos,
    input logic              up_stb,
    input logic              up_late,
    input logic              dn_late,
    input logic              pulse_out
);
    localparam logic [ADDR_W-1:0] LAST_POS = {ADDR_W{1'b1}};

    // R4
    pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && tick && pos != LAST_POS) |=> (pos == $past(pos) + 1'b1));

    // R4
    run_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && tick && pos == LAST_POS) |=> (state == ST_IDLE));

    // R4
    idle_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (pos == LAST_POS));

    // R5
    rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_out) |-> $past(up_late));

    // R5
    fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse_out) |-> $past(dn_late));

    // R7
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_late && dn_late) |=> !pulse_out);

    // R8
    no_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |=> (state != ST_ARMED));

    // R9
    strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(up_stb) |-> ($past(state) == ST_RUN));
endmodule

bind pulse_pattern_gen ppg_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk_in),
    .rst_n     (rst_n),
    .tick      (tick),
    .state     (state_q),
    .pos       (pos_q),
    .up_stb    (up_stb),
    .up_late   (up_late),
    .dn_late   (dn_late),
    .pulse_out (pulse_out)
);

// File: tb/sim_pulse_pattern_gen.sv
`timescale 1ns/1ps
module sim_pulse_pattern_gen;
    localparam int RATIO_M1 = 3;
    localparam int ADDR_W   = 4;
    localparam int R        = RATIO_M1 + 1;
    localparam int DEPTH    = 1 << ADDR_W;
    localparam int DLY_W    = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              trig_in = 1'b0;
    logic              cfg_we = 1'b0;
    logic [ADDR_W-1:0] cfg_addr = '0;
    logic              cfg_up_bit = 1'b0;
    logic              cfg_dn_bit = 1'b0;
    logic [DLY_W-1:0]  up_delay = '0;
    logic [DLY_W-1:0]  dn_delay = '0;
    logic              pulse_out;

    pulse_pattern_gen #(.RATIO_M1(RATIO_M1), .ADDR_W(ADDR_W)) u0 (
        .clk_in     (clk),
        .rst_n      (rst_n),
        .trig_in    (trig_in),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_up_bit (cfg_up_bit),
        .cfg_dn_bit (cfg_dn_bit),
        .up_delay   (up_delay),
        .dn_delay   (dn_delay),
        .pulse_out  (pulse_out)
    );

    always #2 clk = ~clk;   // 250 MHz

    int    vectors = 0;
    int    fails = 0;
    string tag = "R1";

    // Behavioural reference: event lists keyed by fast edge number
    int edge_n = 0;
    int free_edge = 0;
    bit prev_trig = 1'b0;
    bit exp_q = 1'b0;
    bit m_up [DEPTH];
    bit m_dn [DEPTH];
    bit up_at [int];
    bit dn_at [int];

    always @(posedge clk) begin
        if (rst_n) begin
            edge_n++;
            if (trig_in && !prev_trig) begin
                int acc_e;
                acc_e = edge_n + 2;
                if (acc_e >= free_edge) begin
                    int start_e;
                    start_e   = (acc_e / R + 1) * R;
                    free_edge = start_e + R * DEPTH + 1;
                    for (int c = 0; c < DEPTH; c++) begin
                        if (m_up[c]) up_at[start_e + R * (c + 1) + 1 + int'(up_delay)] = 1'b1;
                        if (m_dn[c]) dn_at[start_e + R * (c + 1) + 1 + int'(dn_delay)] = 1'b1;
                    end
                end
            end
            prev_trig = trig_in;
            if (dn_at.exists(edge_n))      exp_q = 1'b0;
            else if (up_at.exists(edge_n)) exp_q = 1'b1;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            vectors++;
            if (pulse_out !== exp_q) begin
                fails++;
                $display("FAIL %s edge %0d: pulse_out=%0b expected %0b", tag, edge_n, pulse_out, exp_q);
            end
        end
    end

    task automatic write_pos(input int a, input bit up_b, input bit dn_b);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = ADDR_W'(a); cfg_up_bit = up_b; cfg_dn_bit = dn_b;
        repeat (R) @(negedge clk);   // spans exactly one tick edge
        cfg_we = 1'b0;
        m_up[a] = up_b;
        m_dn[a] = dn_b;
    endtask

    task automatic fire_trig();
        @(negedge clk);
        trig_in = 1'b1;
        repeat (3) @(negedge clk);
        trig_in = 1'b0;
    endtask

    task automatic run_once();
        fire_trig();
        repeat (R * DEPTH + 20) @(negedge clk);
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: output low in reset and right after release
        vectors++;
        if (pulse_out !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: pulse_out=%0b expected 0", pulse_out);
        end
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1: run over cleared tables keeps output low
        tag = "R1";
        run_once();

        // R2/R3/R5: basic set and clear positions, zero delays
        tag = "R2/R3/R5";
        write_pos(2, 1'b1, 1'b0);
        write_pos(4, 1'b0, 1'b1);
        write_pos(7, 1'b1, 1'b0);
        write_pos(9, 1'b0, 1'b1);
        run_once();

        // R6: independent non-zero delays on each edge
        tag = "R6";
        up_delay = 2'd3; dn_delay = 2'd1;
        run_once();
        up_delay = 2'd0; dn_delay = 2'd2;
        repeat (3) @(negedge clk);
        run_once();

        // R7: both bits at one position, width = dn_delay - up_delay
        tag = "R7";
        write_pos(2, 1'b0, 1'b0);
        write_pos(4, 1'b0, 1'b0);
        write_pos(7, 1'b0, 1'b0);
        write_pos(9, 1'b0, 1'b0);
        write_pos(6, 1'b1, 1'b1);
        up_delay = 2'd1; dn_delay = 2'd3;
        run_once();
        up_delay = 2'd2; dn_delay = 2'd2;   // equal: clear wins, no pulse
        run_once();

        // R8: retrigger during a run is ignored
        tag = "R8";
        write_pos(10, 1'b1, 1'b0);
        write_pos(11, 1'b0, 1'b1);
        up_delay = 2'd3; dn_delay = 2'd0;
        fire_trig();
        repeat (30) @(negedge clk);
        fire_trig();
        repeat (R * DEPTH + 20) @(negedge clk);

        // R9: last position marked, parked counter must stay quiet
        tag = "R9";
        write_pos(6, 1'b0, 1'b0);
        write_pos(10, 1'b0, 1'b0);
        write_pos(11, 1'b0, 1'b0);
        write_pos(DEPTH - 1, 1'b1, 1'b1);
        up_delay = 2'd0; dn_delay = 2'd1;
        run_once();
        repeat (40) @(negedge clk);

        // R4: adjacent positions each act once
        tag = "R4";
        write_pos(DEPTH - 1, 1'b0, 1'b0);
        write_pos(0, 1'b1, 1'b1);
        write_pos(1, 1'b1, 1'b1);
        up_delay = 2'd0; dn_delay = 2'd2;
        run_once();

        // R2: a one-cycle write that misses every tick edge changes nothing
        tag = "R2";
        write_pos(0, 1'b0, 1'b0);
        write_pos(1, 1'b0, 1'b0);
        @(negedge clk);
        while ((edge_n % R) != 1) @(negedge clk);
        cfg_we = 1'b1; cfg_addr = ADDR_W'(3); cfg_up_bit = 1'b1; cfg_dn_bit = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0;
        run_once();

        report();
        $finish;
    end

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        report();
        $finish;
    end
endmodule